// File: doc/BRIEF.md
# Two-Stage Compare Watchdog

This block watches for software that has stopped responding. A free-running 64-bit system count comes in as an input. The watchdog holds an absolute 64-bit deadline and compares the count against it. It does not count down. When the count reaches the deadline for the first time, the block raises a level warning interrupt and moves the deadline one period further on. If software still does nothing before that second deadline, the block raises a level reset request. That request stays high until the system reset input clears it.

Software reaches the block through two register windows on a simple single-cycle bus. The control window holds the status/enable word, the period and the deadline. The refresh window holds a single kick register. A refresh loads the deadline with the current count plus the period and clears the warning. Any of three writes causes a refresh: a write of any value to the kick register, a write to the status/enable word, or a write to the period. A flag records that the reset request fired. This flag is cleared only by power-on reset, so boot code can find out why the chip restarted.

Top module: `wdg_two_stage`

## Requirements
- R1: While `por` or `rst` is high, and after it falls, `irq_o` and `rst_req_o` are 0, and the status word (0x000) and period (0x008) read back 0.
- R2: In the control window, reads return status at 0x000 with bit 0 = enable, bit 1 = warning, bit 2 = reset-fired. They return the period at 0x008, deadline bits 31:0 at 0x010 and deadline bits 63:32 at 0x014. `bus_rdata` is valid from the clock edge that samples `bus_rd`.
- R3: A write of any data to address 0x000 of the refresh window (`bus_win`=1) loads the deadline with the count seen at that edge plus the period, and clears the warning and `irq_o`.
- R4: A write to the status word sets enable from data bit 0 and also refreshes. Writing 0 stops all stage changes.
- R5: A write to the period stores it and refreshes using the new period value.
- R6: When enabled and the warning is clear, the first edge at which count ≥ deadline sets the warning and `irq_o`, and reloads the deadline to that count plus the period.
- R7: When enabled and the warning is already set, an edge at which count ≥ deadline sets the reset-fired flag and `rst_req_o`.
- R8: While enable is 0, neither `irq_o` nor `rst_req_o` rises, whatever the count.
- R9: `rst_req_o` stays high through refreshes until `rst` clears it. The reset-fired flag survives `rst` and is cleared only by `por`.
- R10: Address 0xFCC reads the identification value `ID_VALUE` in both windows.
- R11: A refresh at the same edge as a deadline match wins: no warning is raised, and the deadline becomes that count plus the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on reset; clears everything, including the reset-fired flag |
| rst | input | 1 | Synchronous system reset; clears everything except the reset-fired flag |
| sys_cnt | input | 2*DATA_W | Free-running system count |
| bus_win | input | 1 | Window select: 0 control, 1 refresh |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte offset inside the selected window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level warning interrupt (first stage) |
| rst_req_o | output | 1 | Level reset request (second stage) |

## Verification
The assertions assume that `por` is high at time zero and that `sys_cnt` moves forward monotonically. They also assume that a bus access is never a read and a write in the same cycle. The stimulus meets all three assumptions. It pulses `por` first and steps the count by one on every falling edge, well away from wrap-around. Every access is a single strobe set up after a falling edge, and the bench records the count the design will see at the next rising edge. The deadline-collision case is hit by timing a kick so that it lands exactly at the edge where the count equals the deadline.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [11:0] A_CSR  = 12'h000;
  localparam logic [11:0] A_OFS  = 12'h008;
  localparam logic [11:0] A_CMPL = 12'h010;
  localparam logic [11:0] A_CMPH = 12'h014;
  localparam logic [11:0] A_KICK = 12'h000;
  localparam logic [11:0] A_ID   = 12'hFCC;

  localparam int B_EN  = 0;
  localparam int B_ST0 = 1;
  localparam int B_ST1 = 2;

  typedef enum logic {WIN_CTL = 1'b0, WIN_RFSH = 1'b1} wdg_win_e;
endpackage

// File: rtl/wdg_decode.sv
module wdg_decode import wdg_pkg::*; #(
  parameter int ADDR_W = 12
) (
  input  logic              win,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_csr,
  output logic              wr_ofs,
  output logic              refresh
);
  logic ctl_win;
  logic kick;

  always_comb begin
    ctl_win = (wdg_win_e'(win) == WIN_CTL);
    wr_csr  = wr && ctl_win && (addr == ADDR_W'(A_CSR));
    wr_ofs  = wr && ctl_win && (addr == ADDR_W'(A_OFS));
    kick    = wr && !ctl_win && (addr == ADDR_W'(A_KICK));
    refresh = kick || wr_csr || wr_ofs;
  end
endmodule

// File: rtl/wdg_stage.sv
module wdg_stage import wdg_pkg::*; #(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_csr,
  input  logic              wr_ofs,
  input  logic              refresh,
  output logic              en_o,
  output logic              st0_o,
  output logic              st1_o,
  output logic              req_o,
  output logic [DATA_W-1:0] ofs_o,
  output logic [CNT_W-1:0]  cmp_o
);
  logic [DATA_W-1:0] ofs_q, ofs_nx;
  logic [CNT_W-1:0]  cmp_q;
  logic              en_q, st0_q, st1_q, req_q;
  logic              due;

  always_comb begin
    ofs_nx = wr_ofs ? wdata : ofs_q;
    due    = en_q && (cnt >= cmp_q);
  end

  // sticky flag: only power-on clears it
  always_ff @(posedge clk) begin
    if (por) st1_q <= 1'b0;
    else if (!rst && !refresh && due && st0_q) st1_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (por || rst) begin
      en_q  <= 1'b0;
      st0_q <= 1'b0;
      req_q <= 1'b0;
      ofs_q <= '0;
      cmp_q <= '0;
    end else begin
      ofs_q <= ofs_nx;
      if (wr_csr) en_q <= wdata[B_EN];
      if (refresh) begin
        cmp_q <= cnt + {{(CNT_W-DATA_W){1'b0}}, ofs_nx};
        st0_q <= 1'b0;
      end else if (due) begin
        if (!st0_q) begin
          st0_q <= 1'b1;
          cmp_q <= cnt + {{(CNT_W-DATA_W){1'b0}}, ofs_q};
        end else begin
          req_q <= 1'b1;
        end
      end
    end
  end

  assign en_o  = en_q;
  assign st0_o = st0_q;
  assign st1_o = st1_q;
  assign req_o = req_q;
  assign ofs_o = ofs_q;
  assign cmp_o = cmp_q;
endmodule

// File: rtl/wdg_two_stage.sv
module wdg_two_stage import wdg_pkg::*; #(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] ID_VALUE = 32'h5744_0101
) (
  input  logic                clk,
  input  logic                por,
  input  logic                rst,
  input  logic [2*DATA_W-1:0] sys_cnt,
  input  logic                bus_win,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_o,
  output logic                rst_req_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic              wr_csr, wr_ofs, refresh_s;
  logic              en_q, st0_q, st1_q, req_q;
  logic [DATA_W-1:0] ofs_q, csr_w, rd_nx;
  logic [CNT_W-1:0]  cmp_q;

  wdg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .win(bus_win), .wr(bus_wr), .addr(bus_addr),
    .wr_csr(wr_csr), .wr_ofs(wr_ofs), .refresh(refresh_s)
  );

  wdg_stage #(.DATA_W(DATA_W)) u_stg (
    .clk(clk), .por(por), .rst(rst), .cnt(sys_cnt), .wdata(bus_wdata),
    .wr_csr(wr_csr), .wr_ofs(wr_ofs), .refresh(refresh_s),
    .en_o(en_q), .st0_o(st0_q), .st1_o(st1_q), .req_o(req_q),
    .ofs_o(ofs_q), .cmp_o(cmp_q)
  );

  always_comb begin
    csr_w        = '0;
    csr_w[B_EN]  = en_q;
    csr_w[B_ST0] = st0_q;
    csr_w[B_ST1] = st1_q;
    rd_nx        = '0;
    if (bus_addr == ADDR_W'(A_ID))
      rd_nx = DATA_W'(ID_VALUE);
    else if (wdg_win_e'(bus_win) == WIN_CTL) begin
      if (bus_addr == ADDR_W'(A_CSR))       rd_nx = csr_w;
      else if (bus_addr == ADDR_W'(A_OFS))  rd_nx = ofs_q;
      else if (bus_addr == ADDR_W'(A_CMPL)) rd_nx = cmp_q[DATA_W-1:0];
      else if (bus_addr == ADDR_W'(A_CMPH)) rd_nx = cmp_q[CNT_W-1:DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (por || rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_nx;
  end

  assign irq_o     = st0_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk (
  input logic clk,
  input logic por,
  input logic rst,
  input logic irq,
  input logic req,
  input logic en,
  input logic st1,
  input logic refresh
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (por)
    rst |=> (!irq && !req));
  p_refresh_clears_r3: assert property (@(posedge clk) disable iff (por || rst)
    refresh |=> !irq);
  p_escalate_from_warn_r7: assert property (@(posedge clk) disable iff (por)
    $rose(st1) |-> $past(irq));
  p_warn_needs_en_r8: assert property (@(posedge clk) disable iff (por || rst)
    $rose(irq) |-> $past(en));
  p_req_sticky_r9: assert property (@(posedge clk) disable iff (por || rst)
    req |=> req);
  p_req_has_flag_r9: assert property (@(posedge clk) disable iff (por)
    req |-> st1);
endmodule

bind wdg_two_stage wdg_chk u_chk (
  .clk(clk), .por(por), .rst(rst), .irq(irq_o), .req(rst_req_o),
  .en(en_q), .st1(st1_q), .refresh(refresh_s)
);

// File: tb/test_wdg_two_stage.sv
module test_wdg_two_stage;
  localparam int CLK_P = 10;
  localparam logic [31:0] ID = 32'h5744_0101;

  logic        clk = 1'b0, por = 1'b1, rst = 1'b0;
  logic [63:0] cnt = 64'd1000;
  logic        bus_win = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq_o, rst_req_o;

  wdg_two_stage #(.ID_VALUE(ID)) i_wdg_two_stage (
    .clk(clk), .por(por), .rst(rst), .sys_cnt(cnt), .bus_win(bus_win),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always #(CLK_P/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    cnt = cnt + 64'd1;
  end

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t       sb_q[$];
  int          n_run = 0, n_fail = 0;
  logic [63:0] wr_cnt, cexp;
  bit          done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic win, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_win = win; bus_addr = a; bus_wdata = d; bus_wr = 1'b1; wr_cnt = cnt;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic win, input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk); #1;
    bus_win = win; bus_addr = a; bus_rd = 1'b1;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  // monitor: pops one expected item per read strobe sampled at a rising edge
  initial forever begin
    item_t it;
    @(posedge clk);
    if (bus_rd) begin
      @(negedge clk); #2;
      it = sb_q.pop_front();
      chk(it.tag, {32'd0, bus_rdata}, {32'd0, it.exp});
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    por = 1'b0;
    cyc(1);
    chk("R1 irq after reset", {63'd0, irq_o}, 64'd0);
    chk("R1 req after reset", {63'd0, rst_req_o}, 64'd0);
    rd(1'b0, 12'h000, 32'd0, "R1 status after reset");
    rd(1'b0, 12'h008, 32'd0, "R1 period after reset");
    rd(1'b0, 12'hFCC, ID, "R10 id in control window");
    rd(1'b1, 12'hFCC, ID, "R10 id in refresh window");

    // period write refreshes with new value
    wr(1'b0, 12'h008, 32'd20);
    cexp = wr_cnt + 64'd20;
    rd(1'b0, 12'h008, 32'd20, "R2 period readback");
    rd(1'b0, 12'h010, cexp[31:0], "R5 deadline low after period write");
    rd(1'b0, 12'h014, cexp[63:32], "R5 deadline high after period write");

    // disabled: deadline passes without effect
    cyc(40);
    chk("R8 irq stays low while disabled", {63'd0, irq_o}, 64'd0);
    rd(1'b0, 12'h000, 32'd0, "R8 status while disabled");

    wr(1'b0, 12'h000, 32'd1);
    cexp = wr_cnt + 64'd20;
    rd(1'b0, 12'h000, 32'd1, "R4 enable bit set");
    rd(1'b0, 12'h010, cexp[31:0], "R4 control write refreshes");

    wr(1'b1, 12'h000, 32'hDEAD_BEEF);
    cexp = wr_cnt + 64'd20;
    rd(1'b0, 12'h010, cexp[31:0], "R3 kick reloads deadline");

    for (int i = 0; i < 200; i++) begin @(negedge clk); #1; if (irq_o) break; end
    chk("R6 warning at deadline", cnt, cexp + 64'd1);
    cexp = cexp + 64'd20;
    rd(1'b0, 12'h000, 32'd3, "R2 status with warning");
    rd(1'b0, 12'h010, cexp[31:0], "R6 deadline reloaded");

    wr(1'b1, 12'h000, 32'd0);
    cexp = wr_cnt + 64'd20;
    chk("R3 kick clears warning", {63'd0, irq_o}, 64'd0);

    for (int i = 0; i < 200; i++) begin @(negedge clk); #1; if (irq_o) break; end
    chk("R6 second warning", cnt, cexp + 64'd1);
    cexp = cexp + 64'd20;
    for (int i = 0; i < 200; i++) begin @(negedge clk); #1; if (rst_req_o) break; end
    chk("R7 reset request at second deadline", cnt, cexp + 64'd1);
    rd(1'b0, 12'h000, 32'd7, "R7 status with both stages");

    wr(1'b1, 12'h000, 32'd5);
    cyc(5);
    chk("R9 request survives kick", {63'd0, rst_req_o}, 64'd1);

    @(negedge clk); #1; rst = 1'b1;
    @(negedge clk); #1; rst = 1'b0;
    chk("R9 rst clears request", {63'd0, rst_req_o}, 64'd0);
    chk("R1 rst clears irq", {63'd0, irq_o}, 64'd0);
    rd(1'b0, 12'h000, 32'd4, "R9 flag survives rst");
    cyc(5);
    chk("R9 request stays low after rst", {63'd0, rst_req_o}, 64'd0);

    @(negedge clk); #1; por = 1'b1;
    @(negedge clk); #1; por = 1'b0;
    rd(1'b0, 12'h000, 32'd0, "R9 por clears flag");

    // kick collides with deadline
    wr(1'b0, 12'h008, 32'd30);
    wr(1'b0, 12'h000, 32'd1);
    cexp = wr_cnt + 64'd30;
    for (int i = 0; i < 200; i++) begin
      if (cnt == cexp - 64'd1) break;
      @(negedge clk); #1;
    end
    wr(1'b1, 12'h000, 32'd0);
    chk("R11 kick edge equals deadline", wr_cnt, cexp);
    chk("R11 no warning on collision", {63'd0, irq_o}, 64'd0);
    cexp = cexp + 64'd30;
    rd(1'b0, 12'h010, cexp[31:0], "R11 deadline from kick");

    wr(1'b0, 12'h000, 32'd0);
    cyc(50);
    chk("R4 disabled by writing zero", {63'd0, irq_o}, 64'd0);
    rd(1'b0, 12'h000, 32'd0, "R4 status after disable");

    cyc(3);
    for (int i = 0; i < 20; i++) begin if (sb_q.size() == 0) break; cyc(1); end
    chk("scoreboard drained", 64'(sb_q.size()), 64'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule